// File: doc/BRIEF.md
# Long-Burst SPI Transmit Serializer

This block is the transmit side of an SPI master. It shifts out one chip-select burst whose length can be set anywhere from 1 to 4096 bits. The transmit data arrives as 32-bit words from a FIFO read port. The length field holds the bit count minus one. It is captured when `start` is pulsed while the block is idle.

When a burst is longer than one word, the serializer sends the short remainder first. The first word popped contributes only its low `((field mod 32) + 1)` bits. Every word popped after it contributes all 32 bits. Inside each segment, bits go out most significant first.

Chip select stays low for the whole burst. MOSI changes only while SCLK is low. A fixed divider parameter sets the SCLK half-period. If the FIFO is empty when the next word is needed, the clock stops in its low state until data arrives. A one-cycle `done` pulse closes each burst.

Top module: `spi_burst_tx`

## Requirements
- R1: A burst started with length field value F produces exactly F+1 rising edges of `sclk`.
- R2: The first word of a burst supplies its low H bits, where H = (F mod 32) + 1. For example, F = 0x020 sends only bit 0, F = 0x021 sends bits 1..0, and F = 47 sends bits 15..0.
- R3: A burst pops exactly (F div 32) + 1 words, in FIFO order. Every word after the first supplies all 32 bits.
- R4: Within a segment of length L, MOSI presents word bit L-1 first and bit 0 last. Each bit is sampled on a rising edge of `sclk`.
- R5: `cs_n` (active low) is high while idle. It is low from the cycle after `start` until the cycle after the last bit's high phase ends. Every rising edge of `sclk` occurs while `cs_n` is low.
- R6: When a new word is needed and `fifo_empty` is high, the block does not pop and holds `sclk` low. It resumes with the correct bit stream once a word is available.
- R7: `mosi` is stable for the whole time `sclk` is high. Each high phase of `sclk` lasts exactly DIV clock cycles.
- R8: `done` is high for exactly one cycle, which is the first cycle with `cs_n` high after the burst. `busy` is high from the cycle after `start` through the `done` cycle, and low in the cycle after `done`.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The running burst keeps its length and data.
- R10: `fifo_pop` is never high while `fifo_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a burst (accepted only when idle) |
| len_field | input | 12 | Burst length in bits minus one |
| fifo_data | input | 32 | Word at the head of the transmit FIFO |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_pop | output | 1 | Consume the head word this cycle |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |

## Verification
A segment boundary can occur in the same cycle as an empty FIFO. The falling edge that ends a segment asks for the next word at the moment the FIFO may have nothing to give. The bench provokes this by forcing `fifo_empty` high at random cycles while words still remain, so that some stalls land on exactly that boundary. It then judges the result in three ways: the received bit stream must match a model built from the head-length rule, no pop may occur while the FIFO is empty, and the number of pops must equal the word count. A second collision, a `start` pulse arriving mid-burst, is checked the same way: the bit count and bit stream of the running burst must stay unchanged.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_LOW,
    ST_HIGH,
    ST_DONE
  } tx_state_t;

  // bits taken from the first word of a burst
  function automatic int unsigned head_bits(int unsigned field, int unsigned word_w);
    return (field % word_w) + 1;
  endfunction

  // number of words a burst consumes
  function automatic int unsigned burst_words(int unsigned field, int unsigned word_w);
    return (field / word_w) + 1;
  endfunction

endpackage

// File: rtl/spi_seg_plan.sv
module spi_seg_plan #(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          plan_start,
  input  logic [LEN_W-1:0]              len_field,
  input  logic                          seg_take,
  output logic [$clog2(WORD_W):0]       seg_len,
  output logic                          words_pending
);
  import spi_burst_pkg::*;
  localparam int LOG_W = $clog2(WORD_W);
  localparam int SEG_W = LOG_W + 1;
  localparam int CNT_W = LEN_W - LOG_W + 1;

  logic             head_q;
  logic [SEG_W-1:0] head_len_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q     <= 1'b0;
      head_len_q <= '0;
      cnt_q      <= '0;
    end else if (plan_start) begin
      head_q     <= 1'b1;
      head_len_q <= SEG_W'(head_bits(32'(len_field), WORD_W));
      cnt_q      <= CNT_W'(burst_words(32'(len_field), WORD_W));
    end else if (seg_take) begin
      head_q <= 1'b0;
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign seg_len       = head_q ? head_len_q : SEG_W'(WORD_W);
  assign words_pending = (cnt_q != '0);

  // R3: never take more words than the burst needs
  assert_no_extra_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seg_take |-> (cnt_q != '0));

endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
  parameter int WORD_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [WORD_W-1:0]       load_word,
  input  logic [$clog2(WORD_W):0] load_len,
  input  logic                    shift,
  output logic                    msb,
  output logic                    seg_last_bit
);
  localparam int SEG_W = $clog2(WORD_W) + 1;
  localparam logic [SEG_W-1:0] WORD_L = SEG_W'(WORD_W);

  logic [WORD_W-1:0] shreg;
  logic [SEG_W-1:0]  bits_left;
  logic [SEG_W-1:0]  sh_amt;

  // align bit (len-1) of the word to the output position
  assign sh_amt = WORD_L - load_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      bits_left <= '0;
    end else if (load) begin
      shreg     <= load_word << sh_amt;
      bits_left <= load_len;
    end else if (shift) begin
      shreg     <= {shreg[WORD_W-2:0], 1'b0};
      bits_left <= bits_left - 1'b1;
    end
  end

  assign msb          = shreg[WORD_W-1];
  assign seg_last_bit = (bits_left == SEG_W'(1));

  // R4: a shift only happens while segment bits remain
  assert_shift_in_segment_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> (bits_left != '0));

  // R2: loaded segment length is within one word
  assert_load_len_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_len != '0 && load_len <= WORD_L));

endmodule

// File: rtl/spi_clk_phase.sv
module spi_clk_phase #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_end
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] cnt;

  assign phase_end = run && (cnt == DW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!run || phase_end) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/spi_burst_tx.sv
module spi_burst_tx #(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 12,
  parameter int DIV    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len_field,
  input  logic [WORD_W-1:0] fifo_data,
  input  logic              fifo_empty,
  output logic              fifo_pop,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic              busy,
  output logic              done
);
  import spi_burst_pkg::*;
  localparam int LOG_W = $clog2(WORD_W);
  localparam int SEG_W = LOG_W + 1;
  localparam int CNT_W = LEN_W - LOG_W + 1;

  tx_state_t st, st_nx;
  logic [LEN_W-1:0] len_q;

  // named internal events
  logic ev_accept;     // start taken in idle
  logic ev_rise;       // sclk rising edge this cycle
  logic ev_fall;       // sclk falling edge this cycle
  logic ev_seg_end;    // last bit of a segment leaves
  logic phase_end;
  logic in_phase;
  logic [SEG_W-1:0] seg_len;
  logic words_pending;
  logic seg_last_bit;
  logic sh_msb;

  assign ev_accept  = (st == ST_IDLE) && start;
  assign in_phase   = (st == ST_LOW) || (st == ST_HIGH);
  assign ev_rise    = (st == ST_LOW) && phase_end;
  assign ev_fall    = (st == ST_HIGH) && phase_end;
  assign ev_seg_end = ev_fall && seg_last_bit;
  assign fifo_pop   = (st == ST_LOAD) && !fifo_empty;

  spi_seg_plan #(.WORD_W(WORD_W), .LEN_W(LEN_W)) i_plan (
    .clk          (clk),
    .rst_n        (rst_n),
    .plan_start   (ev_accept),
    .len_field    (len_field),
    .seg_take     (fifo_pop),
    .seg_len      (seg_len),
    .words_pending(words_pending)
  );

  spi_bit_shifter #(.WORD_W(WORD_W)) i_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (fifo_pop),
    .load_word   (fifo_data),
    .load_len    (seg_len),
    .shift       (ev_fall),
    .msb         (sh_msb),
    .seg_last_bit(seg_last_bit)
  );

  spi_clk_phase #(.DIV(DIV)) i_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (in_phase),
    .phase_end(phase_end)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (start)      st_nx = ST_LOAD;
      ST_LOAD: if (!fifo_empty) st_nx = ST_LOW;
      ST_LOW:  if (phase_end)  st_nx = ST_HIGH;
      ST_HIGH: if (phase_end) begin
        if (!seg_last_bit)      st_nx = ST_LOW;
        else if (words_pending) st_nx = ST_LOAD;
        else                    st_nx = ST_DONE;
      end
      ST_DONE: st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      len_q <= '0;
    end else begin
      st <= st_nx;
      if (ev_accept) len_q <= len_field;
    end
  end

  assign sclk = (st == ST_HIGH);
  assign mosi = sh_msb;
  assign cs_n = (st == ST_IDLE) || (st == ST_DONE);
  assign busy = (st != ST_IDLE);
  assign done = (st == ST_DONE);

  // ---- checker state: edge and pop counts per burst ----
  logic [LEN_W:0]   edge_cnt;
  logic [CNT_W-1:0] pop_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt <= '0;
      pop_cnt  <= '0;
    end else if (ev_accept) begin
      edge_cnt <= '0;
      pop_cnt  <= '0;
    end else begin
      if (ev_rise)  edge_cnt <= edge_cnt + 1'b1;
      if (fifo_pop) pop_cnt  <= pop_cnt + 1'b1;
    end
  end

  // R1: bit count of the finished burst
  assert_bitcount_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (edge_cnt == ({1'b0, len_q} + 1'b1)));

  // R3: word count of the finished burst
  assert_wordcount_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pop_cnt == CNT_W'(burst_words(32'(len_q), WORD_W))));

  // R5: clock only toggles inside chip select
  assert_sclk_in_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  // R6: empty FIFO at a word request holds the clock low
  assert_stall_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOAD && fifo_empty) |=> (!sclk && st == ST_LOAD));

  // R7: data steady across the high phase
  assert_mosi_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R8: done is a single cycle, and marks the rise of chip select
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_cs_rise_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done);

  // R9: length held for the whole burst
  assert_len_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(len_q));

  // R10: no pop from an empty FIFO
  assert_pop_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);

endmodule

// File: tb/test_spi_burst_tx.sv
module test_spi_burst_tx;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 12;
  localparam int DIV    = 2;
  localparam int MAXW   = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0]  len_field = '0;
  logic [WORD_W-1:0] fifo_data = '0;
  logic fifo_empty = 1'b1;
  logic fifo_pop, sclk, mosi, cs_n, busy, done;

  always #4 clk = ~clk;  // 125 MHz

  spi_burst_tx #(.WORD_W(WORD_W), .LEN_W(LEN_W), .DIV(DIV)) i_spi_burst_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .len_field(len_field),
    .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy), .done(done)
  );

  int n_checks = 0;
  int n_fail   = 0;

  logic [WORD_W-1:0] wmem [MAXW];
  bit exp_bits [MAXW*WORD_W];
  bit got_bits [MAXW*WORD_W];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // bench restatement: first word contributes what is left over after whole words
  function automatic int lead_len(int field);
    int total = field + 1;
    int whole = (total / WORD_W) * WORD_W;
    return (total == whole) ? WORD_W : total - whole;
  endfunction

  function automatic int word_count(int field);
    return (field + WORD_W) / WORD_W;
  endfunction

  task automatic run_burst(input int field, input bit stall, input bit restart);
    int nw, total, k, idx, nbits, bad_bits, first_bad, pops;
    int cs_bad, mosi_bad, hi_run, hi_bad, pop_bad, busy_bad, stall_cyc;
    bit pop_prev, sclk_prev, mosi_prev, done_seen, ended, cs_at_done, post_done, post_busy;
    nw = word_count(field);
    total = field + 1;
    for (int w = 0; w < nw; w++) wmem[w] = $urandom();
    k = 0;
    for (int w = 0; w < nw; w++) begin
      int seg;
      seg = (w == 0) ? lead_len(field) : WORD_W;
      for (int b = seg - 1; b >= 0; b--) begin
        exp_bits[k] = wmem[w][b];
        k++;
      end
    end
    idx = 0; nbits = 0; bad_bits = 0; first_bad = -1; pops = 0;
    cs_bad = 0; mosi_bad = 0; hi_run = 0; hi_bad = 0; pop_bad = 0;
    busy_bad = 0; stall_cyc = 0;
    pop_prev = 0; sclk_prev = 0; mosi_prev = 0; done_seen = 0; ended = 0;
    cs_at_done = 0; post_done = 0; post_busy = 0;
    for (int cyc = 0; cyc < 40000 && !ended; cyc++) begin
      @(negedge clk);
      if (pop_prev) idx++;
      start     = (cyc == 0) || (restart && cyc == 7);
      len_field = (cyc == 0) ? LEN_W'(field) : LEN_W'(field ^ 12'h015);
      fifo_data = (idx < nw) ? wmem[idx] : 32'hA5A5_5A5A;
      fifo_empty = (idx >= nw) || (stall && $urandom_range(0, 2) == 0);
      #1;
      if (fifo_pop && fifo_empty) pop_bad++;
      if (fifo_pop) pops++;
      if (fifo_empty && idx < nw && busy && !sclk) stall_cyc++;
      pop_prev = fifo_pop;
      if (sclk && !sclk_prev) begin
        if (nbits < MAXW*WORD_W) begin
          got_bits[nbits] = mosi;
          if (nbits < total && mosi != exp_bits[nbits]) begin
            bad_bits++;
            if (first_bad < 0) first_bad = nbits;
          end
        end
        nbits++;
        if (cs_n) cs_bad++;
      end
      if (sclk && sclk_prev && mosi != mosi_prev) mosi_bad++;
      if (sclk) hi_run++;
      else begin
        if (sclk_prev && hi_run != DIV) hi_bad++;
        hi_run = 0;
      end
      if (done_seen) begin
        post_done = done; post_busy = busy; ended = 1;
      end else begin
        if (cyc >= 1 && !busy) busy_bad++;
        if (done) begin done_seen = 1; cs_at_done = cs_n; end
      end
      sclk_prev = sclk; mosi_prev = mosi;
    end
    start = 0;
    if (!ended) check(0, "R8", "watchdog expired, burst never finished", 0, 1);
    check(nbits == total, restart ? "R1 R9" : "R1", "rising sclk edges", nbits, total);
    check(bad_bits == 0, "R2 R4", "bit stream mismatches (first index)", first_bad, -1);
    check(pops == nw, "R3", "words popped", pops, nw);
    check(cs_bad == 0, "R5", "rising edges with cs_n high", cs_bad, 0);
    check(mosi_bad == 0 && hi_bad == 0, "R7", "mosi changes/bad high phases", mosi_bad + hi_bad, 0);
    check(pop_bad == 0, "R10", "pops while empty", pop_bad, 0);
    check(cs_at_done == 1 && post_done == 0, "R8", "cs_n at done / done after", {cs_at_done, post_done}, 2);
    check(busy_bad == 0 && post_busy == 0, "R8", "busy gaps / busy after done", busy_bad + post_busy, 0);
    if (stall) check(bad_bits == 0 && nbits == total, "R6",
                     $sformatf("stream under %0d stall cycles", stall_cyc), bad_bits, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20251);
    repeat (3) @(negedge clk);
    #1;
    check(cs_n == 1 && busy == 0 && done == 0 && sclk == 0 && fifo_pop == 0,
          "R5", "reset outputs", {cs_n, busy, done, sclk, fifo_pop}, 5'b10000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(cs_n == 1 && busy == 0, "R8", "idle after reset", {cs_n, busy}, 2'b10);

    // directed corners: single bit, one full word, 33, 34, 48, word multiples
    run_burst(0,    0, 0);
    run_burst(31,   0, 0);
    run_burst(32,   0, 0);   // R2: bit 0 then 32 bits
    run_burst(33,   0, 0);   // R2: 2 bits then 32 bits
    run_burst(47,   0, 0);   // R2: 16 bits then 32 bits
    run_burst(63,   1, 0);   // R6 with two full words
    run_burst(64,   1, 1);   // R9 restart mid-burst
    run_burst(100,  0, 1);   // R9
    run_burst(4095, 0, 0);   // longest burst

    for (int i = 0; i < 10; i++) begin
      run_burst($urandom_range(0, 400), bit'($urandom_range(0, 1)), bit'(i % 3 == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    n_checks++;
    n_fail++;
    $display("FAIL R8 global watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule